// File: doc/BRIEF.md
# Programmable Product-Term Array

This block is the sum-of-products front end of a small reprogrammable logic device. It holds a matrix of 64 product terms over 40 literal columns. The columns are the true and the inverted form of 20 input or feedback signals. Every product term is evaluated combinationally. The terms are handed on in eight groups of eight, and each group feeds one output macrocell further down the chip.

The configuration arrives as a serial bit stream of 2706 bits, one bit per clock, with index 0 first. A strobe then marks the load as complete. The block decodes each bit's index and routes it to one of three places: an AND-matrix fuse, a per-term enable fuse, or nowhere. Bits for the signature field and for the macrocell controls belong to other blocks, so they are dropped here. Until a complete stream has been committed, every term output is held at 0.

Top module: `pla_term_array`

## Requirements
- R1: The fuse for term t and column c sits at configuration index 40*t + c. The first row of macrocell group g is therefore at index 320*g, so group 1 starts at 320 and group 7 starts at 2240.
- R2: Column 2k carries signal sigIn[k] in true form, and column 2k+1 carries its complement.
- R3: A fuse bit of 0 connects its column into the term's AND. A bit of 1 leaves the column out. A row with every bit at 1 evaluates to 1.
- R4: A row that connects both the true and the complement column of one signal always evaluates to 0.
- R5: The bit at index 2640 + t enables term t. A value of 0 forces that term to 0, and a value of 1 lets the AND result through.
- R6: Indices 2560 to 2639, 2704 and 2705 have no effect on any term output. This range includes the signature field at 2568 to 2631.
- R7: Each clock with cfgShiftEn high stores cfgBit at the next index, counting up from 0. A cfgDone pulse that arrives once all 2706 bits are in raises cfgLoaded at the following clock edge. Any bits shifted after the 2706th and before cfgDone are discarded.
- R8: While cfgLoaded is 0, every term output is 0. A cfgDone pulse given before all 2706 bits have arrived is ignored, and shifting then continues from where it stopped.
- R9: A shift while cfgLoaded is 1 clears cfgLoaded at that clock edge and starts a new load, with that bit stored at index 0.
- R10: Term t appears on termOut[t]. Group g occupies termOut[8g+7:8g].
- R11: Term outputs follow sigIn within the same cycle, with no register in the path.
- R12: After reset, cfgLoaded is 0 and all term outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgShiftEn | input | 1 | Shift one configuration bit in this cycle |
| cfgBit | input | 1 | Serial configuration data |
| cfgDone | input | 1 | Commit strobe for a completed stream |
| sigIn | input | 20 | Input and feedback signals feeding the columns |
| termOut | output | 64 | Product terms, grouped eight per macrocell |
| cfgLoaded | output | 1 | A complete configuration is active |

## Verification
Term outputs have zero cycles of latency from sigIn. The bench changes sigIn in the middle of a cycle and samples one nanosecond later, with no clock edge in between. cfgLoaded rises at the first rising edge after the cycle in which cfgDone is driven. It falls at the very edge that accepts a restarting shift bit, so the bench reads both at the next falling edge. Every term is compared against a model that works from the fuse image the bench generated, together with hand-derived values for a single literal, a tautology, a contradiction and a disabled term.

// File: rtl/pla_pkg.sv
package pla_pkg;

  localparam int NUM_SIGS        = 20;
  localparam int NUM_COLS        = 2 * NUM_SIGS;
  localparam int NUM_TERMS       = 64;
  localparam int TERMS_PER_GROUP = 8;
  localparam int NUM_GROUPS      = NUM_TERMS / TERMS_PER_GROUP;
  localparam int ENABLE_BASE     = 2640;
  localparam int FUSE_BITS       = 2706;
  localparam int IDX_W           = $clog2(FUSE_BITS + 1);

  // control -> datapath strobes
  typedef struct packed {
    logic             wrEn;
    logic             wrBit;
    logic [IDX_W-1:0] wrIdx;
    logic             termsLive;
  } cfg_strobe_t;

  typedef enum logic [1:0] {
    LD_FILL = 2'd0,  // collecting bits
    LD_FULL = 2'd1,  // all bits in, waiting for commit
    LD_LIVE = 2'd2   // configuration active
  } load_state_t;

endpackage

// File: rtl/pla_cfg_ctrl.sv
module pla_cfg_ctrl
  import pla_pkg::*;
#(
  parameter int FUSE_COUNT = FUSE_BITS
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgShiftEn,
  input  logic        cfgBit,
  input  logic        cfgDone,
  output cfg_strobe_t strobe,
  output logic        cfgLoaded
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FUSE_COUNT - 1);

  load_state_t      loadState;
  logic [IDX_W-1:0] bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadState <= LD_FILL;
      bitCnt    <= '0;
    end else begin
      unique case (loadState)
        LD_FILL: begin
          if (cfgShiftEn) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == LAST_IDX) loadState <= LD_FULL;
          end
        end
        LD_FULL: begin
          // extra shifted bits are dropped here
          if (cfgDone && !cfgShiftEn) loadState <= LD_LIVE;
        end
        LD_LIVE: begin
          if (cfgShiftEn) begin
            loadState <= LD_FILL;
            bitCnt    <= IDX_W'(1);
          end
        end
        default: begin
          loadState <= LD_FILL;
          bitCnt    <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strobe.wrBit     = cfgBit;
    strobe.wrIdx     = (loadState == LD_LIVE) ? '0 : bitCnt;
    strobe.wrEn      = cfgShiftEn && (loadState != LD_FULL);
    strobe.termsLive = (loadState == LD_LIVE);
  end

  assign cfgLoaded = (loadState == LD_LIVE);

endmodule

// File: rtl/pla_and_matrix.sv
module pla_and_matrix
  import pla_pkg::*;
#(
  parameter int SIG_COUNT   = NUM_SIGS,
  parameter int TERM_COUNT  = NUM_TERMS,
  parameter int GROUP_SIZE  = TERMS_PER_GROUP,
  parameter int EN_BASE     = ENABLE_BASE
) (
  input  logic                  clk,
  input  cfg_strobe_t           strobe,
  input  logic [SIG_COUNT-1:0]  sigIn,
  output logic [TERM_COUNT-1:0] termOut
);

  localparam int COL_COUNT   = 2 * SIG_COUNT;
  localparam int ARRAY_BITS  = TERM_COUNT * COL_COUNT;
  localparam int GROUP_COUNT = TERM_COUNT / GROUP_SIZE;
  localparam int TERM_W      = (TERM_COUNT > 1) ? $clog2(TERM_COUNT) : 1;

  logic [ARRAY_BITS-1:0] andFuse;
  logic [TERM_COUNT-1:0] termEnFuse;
  logic [COL_COUNT-1:0]  colVal;

  // fuse-index decoding
  logic              hitArray;
  logic              hitEnable;
  logic [TERM_W-1:0] enSel;

  always_comb begin
    hitArray  = int'(strobe.wrIdx) < ARRAY_BITS;
    hitEnable = (int'(strobe.wrIdx) >= EN_BASE) &&
                (int'(strobe.wrIdx) <  EN_BASE + TERM_COUNT);
    enSel     = TERM_W'(int'(strobe.wrIdx) - EN_BASE);
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn && hitArray)  andFuse[strobe.wrIdx] <= strobe.wrBit;
    if (strobe.wrEn && hitEnable) termEnFuse[enSel]     <= strobe.wrBit;
  end

  // literal columns: true form at even positions, complement at odd
  for (genvar s = 0; s < SIG_COUNT; s++) begin : g_col
    assign colVal[2*s]   = sigIn[s];
    assign colVal[2*s+1] = ~sigIn[s];
  end

  for (genvar g = 0; g < GROUP_COUNT; g++) begin : g_grp
    for (genvar k = 0; k < GROUP_SIZE; k++) begin : g_term
      localparam int T = g * GROUP_SIZE + k;
      logic rowHit;
      // blown fuse (1) removes the column from the product
      assign rowHit     = &(andFuse[T*COL_COUNT +: COL_COUNT] | colVal);
      assign termOut[T] = rowHit & termEnFuse[T] & strobe.termsLive;
    end
  end

endmodule

// File: rtl/pla_term_array.sv
module pla_term_array
  import pla_pkg::*;
#(
  parameter int SIG_COUNT  = NUM_SIGS,
  parameter int TERM_COUNT = NUM_TERMS,
  parameter int GROUP_SIZE = TERMS_PER_GROUP,
  parameter int EN_BASE    = ENABLE_BASE,
  parameter int FUSE_COUNT = FUSE_BITS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgShiftEn,
  input  logic                  cfgBit,
  input  logic                  cfgDone,
  input  logic [SIG_COUNT-1:0]  sigIn,
  output logic [TERM_COUNT-1:0] termOut,
  output logic                  cfgLoaded
);

  cfg_strobe_t strobe;

  pla_cfg_ctrl #(
    .FUSE_COUNT(FUSE_COUNT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgShiftEn(cfgShiftEn),
    .cfgBit    (cfgBit),
    .cfgDone   (cfgDone),
    .strobe    (strobe),
    .cfgLoaded (cfgLoaded)
  );

  pla_and_matrix #(
    .SIG_COUNT (SIG_COUNT),
    .TERM_COUNT(TERM_COUNT),
    .GROUP_SIZE(GROUP_SIZE),
    .EN_BASE   (EN_BASE)
  ) u_matrix (
    .clk    (clk),
    .strobe (strobe),
    .sigIn  (sigIn),
    .termOut(termOut)
  );

endmodule

// File: rtl/pla_term_array_chk.sv
module pla_term_array_chk #(
  parameter int TERM_COUNT = 64
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  cfgShiftEn,
  input logic                  cfgDone,
  input logic                  cfgLoaded,
  input logic [TERM_COUNT-1:0] termOut
);

  // R8: nothing leaves the array before a commit
  assert_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoaded |-> termOut == '0);

  // R9: a shift during live operation restarts the load
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgShiftEn && cfgLoaded) |=> !cfgLoaded);

  // R7: going live only follows a commit strobe with no shift
  assert_commit_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgLoaded) |-> ($past(cfgDone) && !$past(cfgShiftEn)));

  // R7: a live configuration stays live without shifting
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLoaded && !cfgShiftEn) |=> cfgLoaded);

  // R12: reset leaves the array unloaded
  assert_reset_R12: assert property (@(posedge clk)
    !rstN |=> !cfgLoaded);

endmodule

bind pla_term_array pla_term_array_chk #(.TERM_COUNT(TERM_COUNT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgShiftEn(cfgShiftEn),
  .cfgDone   (cfgDone),
  .cfgLoaded (cfgLoaded),
  .termOut   (termOut)
);

// File: tb/sim_pla_term_array.sv
`timescale 1ns/1ps
module sim_pla_term_array;

  localparam int NS = 20;
  localparam int NT = 64;
  localparam int NC = 40;
  localparam int FB = 2706;
  localparam int EN0 = 2640;

  // {sigIn, expected {t63, t8, t3, t0}}
  localparam logic [23:0] VEC [8] = '{
    {20'h00000, 4'b0100},
    {20'hFFFFF, 4'b1001},
    {20'h00001, 4'b0110},
    {20'h00008, 4'b0101},
    {20'h00C80, 4'b1000},
    {20'h80001, 4'b0100},
    {20'h00C09, 4'b1111},
    {20'h7FFFF, 4'b1011}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgShiftEn = 1'b0;
  logic          cfgBit = 1'b0;
  logic          cfgDone = 1'b0;
  logic [NS-1:0] sigIn = '0;
  logic [NT-1:0] termOut;
  logic          cfgLoaded;

  int checks = 0;
  int failures = 0;

  logic [FB-1:0] img, imgA, imgB, imgC;

  always #10 clk = ~clk;

  pla_term_array u0 (
    .clk(clk), .rstN(rstN), .cfgShiftEn(cfgShiftEn), .cfgBit(cfgBit),
    .cfgDone(cfgDone), .sigIn(sigIn), .termOut(termOut), .cfgLoaded(cfgLoaded)
  );

  function automatic logic [NT-1:0] model(input logic [FB-1:0] im, input logic [NS-1:0] s);
    logic [NT-1:0] r;
    for (int t = 0; t < NT; t++) begin
      logic p;
      p = im[EN0 + t];
      for (int c = 0; c < NC; c++) begin
        logic lit;
        lit = (c % 2 == 0) ? s[c/2] : ~s[c/2];
        if (!im[t*NC + c]) p = p & lit;
      end
      r[t] = p;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setRow(input int t, input logic [NC-1:0] conn);
    img[t*NC +: NC] = ~conn;
  endtask

  task automatic shiftRange(input logic [FB-1:0] im, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      @(negedge clk);
      cfgShiftEn = 1'b1;
      cfgBit = im[i];
    end
    @(negedge clk);
    cfgShiftEn = 1'b0;
  endtask

  task automatic pulseDone();
    cfgDone = 1'b1;
    @(negedge clk);
    cfgDone = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    // build image A
    img = '0;
    for (int t = 0; t < NT; t++) img[EN0 + t] = 1'b1;
    setRow(0, 40'd1 << 6);                      // sig3 literal
    setRow(1, 40'd0);                           // tautology
    setRow(2, (40'd1 << 10) | (40'd1 << 11));   // sig5 & ~sig5
    setRow(3, (40'd1 << 0) | (40'd1 << 39));    // sig0 & ~sig19
    setRow(8, 40'd1 << 15);                     // ~sig7, first row of group 1
    setRow(9, 40'd0);                           // tautology, disabled
    img[EN0 + 9] = 1'b0;
    setRow(63, (40'd1 << 20) | (40'd1 << 22));  // sig10 & sig11
    img[2568 +: 64] = 64'hA5C3_0F96_5A3C_F069;
    imgA = img;
    // image B: only non-array, non-enable fields differ
    imgB = imgA;
    imgB[2560 +: 80] = ~imgA[2560 +: 80];
    imgB[2704] = ~imgA[2704];
    imgB[2705] = ~imgA[2705];
    // image C: enables of terms 1 and 9 swapped
    imgC = imgA;
    imgC[EN0 + 1] = 1'b0;
    imgC[EN0 + 9] = 1'b1;

    repeat (3) @(negedge clk);
    sigIn = 20'hFFFFF;
    #1;
    chk("R12 loaded after reset", 64'(cfgLoaded), 64'd0);
    chk("R12 terms after reset", 64'(termOut), 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R8: partial stream then an early commit
    shiftRange(imgA, 0, 99);
    pulseDone();
    #1;
    chk("R8 early commit ignored", 64'(cfgLoaded), 64'd0);
    chk("R8 terms held low", 64'(termOut), 64'd0);
    shiftRange(imgA, 100, FB - 1);
    #1;
    chk("R8 full but uncommitted", 64'(termOut), 64'd0);
    pulseDone();
    #1;
    chk("R7 loaded after commit", 64'(cfgLoaded), 64'd1);

    // table walk
    for (int i = 0; i < 8; i++) begin
      logic [NS-1:0] s;
      logic [3:0] e;
      @(negedge clk);
      s = VEC[i][23:4];
      e = VEC[i][3:0];
      sigIn = s;
      #1;
      chk("R1 R2 R10 picked terms", 64'({termOut[63], termOut[8], termOut[3], termOut[0]}), 64'(e));
      chk("R3 tautology term1", 64'(termOut[1]), 64'd1);
      chk("R4 contradiction term2", 64'(termOut[2]), 64'd0);
      chk("R5 disabled term9", 64'(termOut[9]), 64'd0);
      chk("R3 R4 R5 all terms vs model", 64'(termOut), 64'(model(imgA, s)));
    end

    // R11: same-cycle response
    @(negedge clk);
    sigIn = 20'h00000;
    #1;
    chk("R11 term8 high", 64'(termOut[8]), 64'd1);
    sigIn = 20'h00080;
    #1;
    chk("R11 term8 low without clock", 64'(termOut[8]), 64'd0);

    // R9: restart while live, loading image B
    @(negedge clk);
    cfgShiftEn = 1'b1;
    cfgBit = imgB[0];
    @(negedge clk);
    cfgShiftEn = 1'b0;
    #1;
    chk("R9 restart clears loaded", 64'(cfgLoaded), 64'd0);
    chk("R9 terms low during reload", 64'(termOut), 64'd0);
    // R7: extra trailing bits are discarded
    shiftRange(imgB, 1, FB - 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      cfgShiftEn = 1'b1;
      cfgBit = 1'b1;
    end
    @(negedge clk);
    cfgShiftEn = 1'b0;
    pulseDone();
    #1;
    chk("R7 loaded after overflow", 64'(cfgLoaded), 64'd1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sigIn = VEC[i][23:4];
      #1;
      chk("R6 R7 unused fields no effect", 64'(termOut), 64'(model(imgA, VEC[i][23:4])));
    end

    // R5: enable fuses swapped in image C
    @(negedge clk);
    cfgShiftEn = 1'b1;
    cfgBit = imgC[0];
    shiftRange(imgC, 1, FB - 1);
    pulseDone();
    sigIn = 20'h00C09;
    #1;
    chk("R5 term1 disabled", 64'(termOut[1]), 64'd0);
    chk("R5 term9 enabled", 64'(termOut[9]), 64'd1);
    chk("R5 image C vs model", 64'(termOut), 64'(model(imgC, 20'h00C09)));

    // R12: reset while live
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    #1;
    chk("R12 reset drops loaded", 64'(cfgLoaded), 64'd0);
    chk("R12 reset clears terms", 64'(termOut), 64'd0);

    summary();
    $finish;
  end

endmodule